// File: doc/BRIEF.md
# MOESI Cache Line Coherence Controller

This block holds the coherence state of one cache line in a multiprocessor that uses a home node to order requests. Its inputs are load and store requests from the local processor, read-shared and read-exclusive snoops from other caches, and response messages (plain data, exclusive data, shared data and acknowledgements). Its outputs are miss requests to the home node, hit completions to the processor and replies to the snooping cache. The data array, the replacement policy, the directory and the interconnect are outside the block; only their message ports appear here.

The line rests in one of six stable states: invalid, shared, exclusive, owned, modified, and a migratory-modified state entered after a store miss. A miss walks through transient states. It waits for data, then waits until the acknowledgement count given in the data response has been reached. One tracking counter serves the single outstanding miss. In the migratory state a remote read takes the line away with exclusive data, and the local copy is dropped. The owned state is reached only from the modified state, and the modified state only through a load miss answered with exclusive data followed by a local store.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset `line_state` is 0 and `proc_ready` is 1, with no output valid. The state code is I=0, S=1, E=2, O=3, M=4, MM=5, IS=6, IM=7, SS=8, XA=9 (exclusive data held, acks pending), MA=10 (store data held, acks pending). Every output is registered, so a change caused by inputs in one cycle shows after the next rising edge.
- R2: A load accepted in I issues a read-shared request (`miss_valid`=1, `miss_excl`=0), enters IS and drops `proc_ready`.
- R3: In IS, a plain data (`resp_kind`=0) or shared data (`resp_kind`=2) response gives a load hit and enters SS. Once all acks are in, SS moves to S.
- R4: In IS, an exclusive data response (`resp_kind`=1) gives a load hit and enters XA. Once all acks are in, XA moves to E. A store in E is a hit that moves the line to M and sends no request.
- R5: A store accepted in I, S or O issues a read-exclusive request (`miss_excl`=1) and enters IM. A data response of any kind moves IM to MA. Once all acks are in, MA moves to MM and gives a store hit (`hit_store`=1) at that moment.
- R6: An ack is `resp_kind`=3. Acks are counted in 4 bits from the start of the miss, including acks that arrive before the data. The expected count is carried on `resp_acks` with the data. An SS, XA or MA state completes in the cycle where the count received, including any ack in that cycle, equals the expected count.
- R7: In MM, a read-shared snoop is answered with exclusive data (`snp_rsp_kind`=2) and the line goes to I.
- R8: A read-shared snoop in M replies with data (`snp_rsp_kind`=1) and moves to O. In O it replies with data and the line stays in O. In E it replies with data and the line moves to S. In S or I it replies with an ack only (`snp_rsp_kind`=0) and the state is unchanged.
- R9: A read-exclusive snoop in E, M, O or MM replies with data (kind 1) and moves to I. In S it replies with an ack and moves to I. In I it replies with an ack.
- R10: A snoop in a transient state is answered with an ack only and does not alter the pending miss. A response in the same cycle is still applied.
- R11: `proc_ready` is low in every transient state. A processor request is accepted only when `proc_ready` is high and no snoop is present in the same cycle. A snoop wins that cycle, and the request produces no hit or miss.
- R12: Loads hit in S, E, O, M and MM. Stores hit in M and MM. Each hit is reported on `hit_valid` with `hit_store` giving the request type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_valid | input | 1 | Processor request present |
| proc_store | input | 1 | 1 = store, 0 = load |
| proc_ready | output | 1 | Request may be accepted this cycle |
| hit_valid | output | 1 | Processor request completed |
| hit_store | output | 1 | Completed request was a store |
| miss_valid | output | 1 | Request to home node |
| miss_excl | output | 1 | 1 = read-exclusive, 0 = read-shared |
| snp_valid | input | 1 | Snoop from another cache |
| snp_excl | input | 1 | 1 = read-exclusive, 0 = read-shared |
| snp_rsp_valid | output | 1 | Reply to the snooping cache |
| snp_rsp_kind | output | 2 | 0 ack, 1 data, 2 exclusive data |
| resp_valid | input | 1 | Response message present |
| resp_kind | input | 2 | 0 data, 1 exclusive data, 2 shared data, 3 ack |
| resp_acks | input | 4 | Expected ack count, valid with data |
| line_state | output | 4 | Current state code |

## Verification
A snoop and a response can fall in the same cycle while a miss is pending. The snoop must get an ack-only reply, and the data or ack must still move the miss forward. The random stimulus mixes snoops into IS, IM and the ack-waiting states while data and acks are flowing. Each cycle is judged against a bench model of the state, the reply kind and the completion cycle. A snoop and a processor request can also meet while the line is stable; directed cases aim a store at an MM line during a read-shared snoop and expect the handoff reply with no hit.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [3:0] {
    ST_I  = 4'd0,
    ST_S  = 4'd1,
    ST_E  = 4'd2,
    ST_O  = 4'd3,
    ST_M  = 4'd4,
    ST_MM = 4'd5,
    ST_IS = 4'd6,
    ST_IM = 4'd7,
    ST_SS = 4'd8,
    ST_XA = 4'd9,
    ST_MA = 4'd10
  } line_st_t;

  localparam logic [1:0] RK_DATA = 2'd0;
  localparam logic [1:0] RK_EXCL = 2'd1;
  localparam logic [1:0] RK_SHRD = 2'd2;
  localparam logic [1:0] RK_ACK  = 2'd3;

  localparam logic [1:0] SR_ACK  = 2'd0;
  localparam logic [1:0] SR_DATA = 2'd1;
  localparam logic [1:0] SR_EXCL = 2'd2;

  function automatic logic is_stable(input line_st_t s);
    return (s == ST_I) || (s == ST_S) || (s == ST_E) ||
           (s == ST_O) || (s == ST_M) || (s == ST_MM);
  endfunction

  function automatic logic is_armed(input line_st_t s);
    return (s == ST_SS) || (s == ST_XA) || (s == ST_MA);
  endfunction

endpackage

// File: rtl/moesi_ack_tracker.sv
module moesi_ack_tracker #(
  parameter int ACK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             count_en,
  input  logic             ack_in,
  input  logic             load_exp,
  input  logic [ACK_W-1:0] exp_in,
  input  logic             armed,
  output logic             done
);
  localparam logic [ACK_W-1:0] CNT_MAX = {ACK_W{1'b1}};

  logic [ACK_W-1:0] cnt_q;
  logic [ACK_W-1:0] exp_q;
  logic [ACK_W-1:0] sum;

  assign sum  = cnt_q + {{(ACK_W-1){1'b0}}, ack_in};
  assign done = armed && (sum == exp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else begin
      if (clear)                   cnt_q <= '0;
      else if (count_en && ack_in) cnt_q <= sum;
      if (load_exp)                exp_q <= exp_in;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (count_en && ack_in && !clear) |-> (cnt_q != CNT_MAX)); // R6

endmodule

// File: rtl/moesi_next_state.sv
module moesi_next_state
  import moesi_pkg::*;
(
  input  line_st_t   st,
  input  logic       acc,
  input  logic       p_store,
  input  logic       s_valid,
  input  logic       s_excl,
  input  logic       r_valid,
  input  logic [1:0] r_kind,
  input  logic       done,
  output line_st_t   ns,
  output logic       mreq_v,
  output logic       mreq_x,
  output logic       hit_v,
  output logic       hit_s,
  output logic       srsp_v,
  output logic [1:0] srsp_k,
  output logic       miss_start
);
  logic r_data;
  assign r_data = r_valid && (r_kind != RK_ACK);

  always_comb begin
    ns         = st;
    mreq_v     = 1'b0;
    mreq_x     = 1'b0;
    hit_v      = 1'b0;
    hit_s      = 1'b0;
    srsp_v     = s_valid;
    srsp_k     = SR_ACK;
    miss_start = 1'b0;
    if (is_stable(st)) begin
      if (s_valid) begin
        case (st)
          ST_S: if (s_excl) ns = ST_I;
          ST_E: begin
            srsp_k = SR_DATA;
            if (s_excl) ns = ST_I; else ns = ST_S;
          end
          ST_M: begin
            srsp_k = SR_DATA;
            if (s_excl) ns = ST_I; else ns = ST_O;
          end
          ST_O: begin
            srsp_k = SR_DATA;
            if (s_excl) ns = ST_I;
          end
          ST_MM: begin
            if (s_excl) srsp_k = SR_DATA; else srsp_k = SR_EXCL;
            ns = ST_I;
          end
          default: ;
        endcase
      end else if (acc) begin
        if ((st == ST_I) || (p_store && ((st == ST_S) || (st == ST_O)))) begin
          miss_start = 1'b1;
          mreq_v     = 1'b1;
          mreq_x     = p_store;
          if (p_store) ns = ST_IM; else ns = ST_IS;
        end else begin
          hit_v = 1'b1;
          hit_s = p_store;
          if (p_store && (st == ST_E)) ns = ST_M;
        end
      end
    end else begin
      case (st)
        ST_IS: if (r_data) begin
          hit_v = 1'b1;
          if (r_kind == RK_EXCL) ns = ST_XA; else ns = ST_SS;
        end
        ST_IM: if (r_data) ns = ST_MA;
        ST_SS: if (done) ns = ST_S;
        ST_XA: if (done) ns = ST_E;
        ST_MA: if (done) begin
          ns    = ST_MM;
          hit_v = 1'b1;
          hit_s = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int ACK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             proc_valid,
  input  logic             proc_store,
  output logic             proc_ready,
  output logic             hit_valid,
  output logic             hit_store,
  output logic             miss_valid,
  output logic             miss_excl,
  input  logic             snp_valid,
  input  logic             snp_excl,
  output logic             snp_rsp_valid,
  output logic [1:0]       snp_rsp_kind,
  input  logic             resp_valid,
  input  logic [1:0]       resp_kind,
  input  logic [ACK_W-1:0] resp_acks,
  output logic [3:0]       line_state
);
  line_st_t   state_q, state_n;
  logic       ready_q, acc, done;
  logic       mreq_v, mreq_x, hit_v, hit_s, srsp_v, miss_start;
  logic [1:0] srsp_k;
  logic       ack_in, waiting_data;

  assign acc          = proc_valid && ready_q && !snp_valid;
  assign ack_in       = resp_valid && (resp_kind == RK_ACK);
  assign waiting_data = (state_q == ST_IS) || (state_q == ST_IM);

  moesi_next_state u_next (
    .st(state_q), .acc(acc), .p_store(proc_store),
    .s_valid(snp_valid), .s_excl(snp_excl),
    .r_valid(resp_valid), .r_kind(resp_kind), .done(done),
    .ns(state_n), .mreq_v(mreq_v), .mreq_x(mreq_x),
    .hit_v(hit_v), .hit_s(hit_s), .srsp_v(srsp_v), .srsp_k(srsp_k),
    .miss_start(miss_start)
  );

  moesi_ack_tracker #(.ACK_W(ACK_W)) u_acks (
    .clk(clk), .rst(rst), .clear(miss_start),
    .count_en(!is_stable(state_q)), .ack_in(ack_in),
    .load_exp(waiting_data && resp_valid && !ack_in),
    .exp_in(resp_acks), .armed(is_armed(state_q)), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_I;
      ready_q       <= 1'b1;
      hit_valid     <= 1'b0;
      hit_store     <= 1'b0;
      miss_valid    <= 1'b0;
      miss_excl     <= 1'b0;
      snp_rsp_valid <= 1'b0;
      snp_rsp_kind  <= SR_ACK;
    end else begin
      state_q       <= state_n;
      ready_q       <= is_stable(state_n);
      hit_valid     <= hit_v;
      hit_store     <= hit_s;
      miss_valid    <= mreq_v;
      miss_excl     <= mreq_x;
      snp_rsp_valid <= srsp_v;
      snp_rsp_kind  <= srsp_k;
    end
  end

  assign proc_ready = ready_q;
  assign line_state = state_q;

  AST_MISS_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    miss_valid |-> ($past(proc_ready) && $past(proc_valid) && !$past(snp_valid))); // R11

  AST_SNOOP_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> snp_rsp_valid); // R8

  AST_TRANSIENT_SNOOP: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && waiting_data && !resp_valid) |=>
      ((line_state == $past(line_state)) && (snp_rsp_kind == SR_ACK))); // R10

  AST_MIGRATORY: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_MM) && snp_valid && !snp_excl) |=>
      ((line_state == 4'd0) && (snp_rsp_kind == SR_EXCL))); // R7

endmodule

// File: tb/moesi_line_ctrl_bench.sv
module moesi_line_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       proc_valid, proc_store, snp_valid, snp_excl, resp_valid;
  logic [1:0] resp_kind;
  logic [3:0] resp_acks;
  logic       proc_ready, hit_valid, hit_store, miss_valid, miss_excl, snp_rsp_valid;
  logic [1:0] snp_rsp_kind;
  logic [3:0] line_state;

  int checks = 0;
  int fails  = 0;

  int m_st, m_cnt, m_exp;
  bit m_rdy;
  bit e_hv, e_hs, e_mv, e_mx, e_sv;
  bit [1:0] e_sk;
  string tg;

  always #(CLK_PERIOD/2) clk = ~clk;

  moesi_line_ctrl u_moesi_line_ctrl (
    .clk(clk), .rst(rst), .proc_valid(proc_valid), .proc_store(proc_store),
    .proc_ready(proc_ready), .hit_valid(hit_valid), .hit_store(hit_store),
    .miss_valid(miss_valid), .miss_excl(miss_excl), .snp_valid(snp_valid),
    .snp_excl(snp_excl), .snp_rsp_valid(snp_rsp_valid), .snp_rsp_kind(snp_rsp_kind),
    .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_acks(resp_acks),
    .line_state(line_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model of the requirements, advanced once per clock
  task automatic model(input bit pv, ps, sv, sg, rv, input bit [1:0] rk, input bit [3:0] ra);
    int ns;
    bit ack, acc;
    ns = m_st; ack = rv && (rk == 2'd3); acc = pv && m_rdy && !sv;
    e_hv = 0; e_hs = 0; e_mv = 0; e_mx = 0; e_sv = sv; e_sk = 2'd0; tg = "R12";
    if (m_st <= 5) begin
      if (sv) begin
        tg = sg ? "R9" : "R8";
        case (m_st)
          1: if (sg) ns = 0;
          2: begin e_sk = 1; ns = sg ? 0 : 1; end
          3: begin e_sk = 1; if (sg) ns = 0; end
          4: begin e_sk = 1; ns = sg ? 0 : 3; end
          5: begin e_sk = sg ? 2'd1 : 2'd2; ns = 0; if (!sg) tg = "R7"; end
          default: ;
        endcase
        if (pv) tg = "R11";
      end else if (acc) begin
        if (m_st == 0 || (ps && (m_st == 1 || m_st == 3))) begin
          e_mv = 1; e_mx = ps; ns = ps ? 7 : 6; m_cnt = 0; tg = ps ? "R5" : "R2";
        end else begin
          e_hv = 1; e_hs = ps;
          if (m_st == 2 && ps) begin ns = 4; tg = "R4"; end
        end
      end
    end else begin
      if (sv) tg = "R10"; else if (pv) tg = "R11";
      case (m_st)
        6: if (rv && !ack) begin e_hv = 1; m_exp = ra; ns = (rk == 1) ? 9 : 8; tg = (rk == 1) ? "R4" : "R3"; end
        7: if (rv && !ack) begin m_exp = ra; ns = 10; tg = "R5"; end
        8, 9, 10: if (m_cnt + int'(ack) == m_exp) begin
          tg = "R6";
          ns = (m_st == 8) ? 1 : (m_st == 9) ? 2 : 5;
          if (m_st == 10) begin e_hv = 1; e_hs = 1; end
        end
        default: ;
      endcase
      if (ack) m_cnt++;
    end
    m_st = ns; m_rdy = (ns <= 5);
  endtask

  task automatic step(input bit pv, ps, sv, sg, rv, input bit [1:0] rk, input bit [3:0] ra);
    @(negedge clk);
    proc_valid = pv; proc_store = ps; snp_valid = sv; snp_excl = sg;
    resp_valid = rv; resp_kind = rk; resp_acks = ra;
    model(pv, ps, sv, sg, rv, rk, ra);
    @(posedge clk); #1;
    chk(tg, {line_state, proc_ready, hit_valid, hit_store, miss_valid, miss_excl, snp_rsp_valid, snp_rsp_kind},
            {m_st[3:0], m_rdy, e_hv, e_hs, e_mv, e_mx, e_sv, e_sk});
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; proc_valid = 0; proc_store = 0; snp_valid = 0; snp_excl = 0;
    resp_valid = 0; resp_kind = 0; resp_acks = 0;
    m_st = 0; m_cnt = 0; m_exp = 0; m_rdy = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1", {line_state, proc_ready, hit_valid, miss_valid, snp_rsp_valid}, {4'd0, 4'b1000});

    // R2/R6: load miss, one ack before data, expected two
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R2", {line_state, proc_ready, miss_valid, miss_excl}, {4'd6, 3'b010});
    step(0, 0, 0, 0, 1, 3, 0);
    step(0, 0, 1, 1, 1, 0, 2);                 // R10: snoop with data
    chk("R10", {snp_rsp_kind, hit_valid, line_state}, {2'd0, 1'b1, 4'd8});
    step(0, 0, 0, 0, 1, 3, 0);
    chk("R6", line_state, 1);
    // R5: upgrade from S with zero acks
    step(1, 1, 0, 0, 0, 0, 0);
    chk("R5", {miss_valid, miss_excl, line_state}, {2'b11, 4'd7});
    step(0, 0, 0, 0, 1, 2, 0);
    idle();
    chk("R5", {line_state, hit_valid, hit_store}, {4'd5, 2'b11});
    // R7/R11: store meets read snoop in MM
    step(1, 1, 1, 0, 0, 0, 0);
    chk("R7", {line_state, snp_rsp_kind, hit_valid}, {4'd0, 2'd2, 1'b0});
    // R4/R8/R9: exclusive path to M, then O, then I
    step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 0);
    idle();
    chk("R4", line_state, 2);
    step(1, 1, 0, 0, 0, 0, 0);
    chk("R4", {line_state, hit_valid, miss_valid}, {4'd4, 2'b10});
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R8", {line_state, snp_rsp_kind}, {4'd3, 2'd1});
    step(0, 0, 1, 1, 0, 0, 0);
    chk("R9", {line_state, snp_rsp_kind}, {4'd0, 2'd1});

    for (int i = 0; i < 4000; i++) begin
      bit pv, ps, sv, sg, rv;
      bit [1:0] rk;
      bit [3:0] ra;
      pv = ($urandom % 2) == 0; ps = $urandom % 2;
      sv = ($urandom % 5) == 0; sg = $urandom % 2;
      rv = 0; rk = 0; ra = 0;
      if (m_st == 6 || m_st == 7) begin
        if (($urandom % 3) == 0) begin
          rv = 1; rk = 2'($urandom % 3); ra = 4'(m_cnt + int'($urandom % 3));
        end else if (m_cnt < 10 && ($urandom % 2) == 0) begin
          rv = 1; rk = 3;
        end
      end else if (m_st >= 8) begin
        if (m_cnt < m_exp && ($urandom % 2) == 0) begin rv = 1; rk = 3; end
      end
      step(pv, ps, sv, sg, rv, rk, ra);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule